// File: doc/BRIEF.md
# Dual-Pipe Result Retirement Stage

This block is the final stage of a pipeline that has two execution pipes: an integer pipe, which also carries memory loads, and a slower floating-point pipe. In each cycle it accepts at most one finished result and turns it into a single register-file write. When both pipes offer a result in the same cycle, the instruction that was issued first is retired first. The pipe that is not served sees its ready signal low and must hold its result until it is accepted.

Each result carries a small sequence tag that the issue logic assigned. Age is found by subtracting the tags modulo the tag width, so the order stays correct after the tag counter wraps around. A load on the integer pipe takes its value from the memory read-data input. If that load has to wait, the block copies the memory data in the first cycle of the wait, so the value is kept after the memory bus moves on. When the load finally retires, the copy is written. A load that is not stalled writes the live bus value. Jumps, NOPs and results aimed at register zero are accepted but do not write. The register-file write port is registered by default, so a write appears one cycle after its result is accepted.

Top module: `dual_retire_wb`

## Requirements
- R1: When only one pipe asserts valid, that pipe's ready is high and its result is accepted.
- R2: When both pipes are valid, the integer result is accepted if its tag is older. The integer tag is older when (int_tag - fp_tag) mod 2^TAG_W has its top bit set, or when the two tags are equal. Otherwise the floating-point result is accepted. This holds across tag wrap-around.
- R3: When both pipes are valid, exactly one ready is high. The pipe that loses holds its result and is accepted in a later cycle.
- R4: An integer result of kind LOAD (int_kind = 1) that is valid but not ready stores mem_rdata from the first cycle of its stall. Later changes on mem_rdata are ignored, and the stored value is the one written when the load retires.
- R5: A LOAD that is accepted in the cycle it first appears writes the value present on mem_rdata in that cycle.
- R6: A NOP (int_kind = 2 or fp_nop = 1) or a JUMP (int_kind = 3) is accepted like any result but produces no register-file write. Kind 0 is an ALU result whose int_value is written.
- R7: An accepted result whose destination is register 0 produces no write.
- R8: The stored-load flag clears in the cycle the stalled load retires, so the next load uses live memory data again.
- R9: With REG_OUT = 1, rf_we, rf_addr and rf_wdata present the accepted result on the clock edge that accepts it, so they are visible for the following cycle. At most one write happens per cycle, and after reset rf_we is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_valid | input | 1 | Integer pipe offers a result |
| int_ready | output | 1 | Integer result accepted this cycle |
| int_kind | input | 2 | 0 ALU, 1 LOAD, 2 NOP, 3 JUMP |
| int_dest | input | ADDR_W | Integer destination register |
| int_value | input | DATA_W | Integer ALU result |
| int_tag | input | TAG_W | Integer sequence tag |
| fp_valid | input | 1 | FP pipe offers a result |
| fp_ready | output | 1 | FP result accepted this cycle |
| fp_nop | input | 1 | FP slot carries a NOP |
| fp_dest | input | ADDR_W | FP destination register |
| fp_value | input | DATA_W | FP result |
| fp_tag | input | TAG_W | FP sequence tag |
| mem_rdata | input | DATA_W | Memory read data for loads |
| rf_we | output | 1 | Register-file write enable |
| rf_addr | output | ADDR_W | Register-file write address |
| rf_wdata | output | DATA_W | Register-file write data |

## Verification
The bench offers results on both pipes at once with tags on each side of the wrap point, including equal tags. An age compare that does not wrap would retire the younger result, and a wrong tie rule would serve the FP pipe. It stalls a load for several cycles while mem_rdata changes every cycle. A design that does not store the data, or that overwrites the stored copy on each stall cycle, writes a later bus value. It then sends a fresh load right after the stalled one; a flag that fails to clear would write stale data. NOP, JUMP and register-zero results are checked for being accepted without a write, which catches a design that either stalls them or writes them.

// File: rtl/wb_pkg.sv
package wb_pkg;
   typedef enum logic [1:0] {
      KIND_ALU  = 2'd0,
      KIND_LOAD = 2'd1,
      KIND_NOP  = 2'd2,
      KIND_JUMP = 2'd3
   } res_kind_e;

   function automatic logic kind_writes(input res_kind_e k);
      return (k == KIND_ALU) || (k == KIND_LOAD);
   endfunction
endpackage

// File: rtl/wb_age_order.sv
module wb_age_order #(
   parameter int TAG_W = 4
) (
   input  logic [TAG_W-1:0] a_tag,
   input  logic [TAG_W-1:0] b_tag,
   output logic             a_first
);
   if (TAG_W < 2) begin : g_bad_tag
      $error("wb_age_order: TAG_W must be at least 2");
   end

   logic [TAG_W-1:0] diff;

   always_comb begin
      diff    = a_tag - b_tag;
      a_first = diff[TAG_W-1] || (diff == '0);
   end
endmodule

// File: rtl/wb_load_hold.sv
module wb_load_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_wait,
   input  logic              load_fire,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [DATA_W-1:0] load_data,
   output logic              held_v
);
   if (DATA_W < 1) begin : g_bad_data
      $error("wb_load_hold: DATA_W must be positive");
   end

   logic [DATA_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_v <= 1'b0;
         held_q <= '0;
      end else if (load_fire) begin
         held_v <= 1'b0;
      end else if (load_wait && !held_v) begin
         held_v <= 1'b1;
         held_q <= mem_rdata;
      end
   end

   always_comb load_data = held_v ? held_q : mem_rdata;

   // R4
   held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_v && $past(held_v) |-> $stable(held_q));
   // R8
   held_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_fire |=> !held_v);
   // R4
   held_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load_wait && !load_fire |=> held_v);
endmodule

// File: rtl/wb_rf_port.sv
module wb_rf_port #(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_d,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [DATA_W-1:0] data_d,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("wb_rf_port: ADDR_W must be positive");
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rf_we    <= 1'b0;
            rf_addr  <= '0;
            rf_wdata <= '0;
         end else begin
            rf_we    <= we_d;
            rf_addr  <= addr_d;
            rf_wdata <= data_d;
         end
      end
   end else begin : g_comb
      always_comb begin
         rf_we    = we_d;
         rf_addr  = addr_d;
         rf_wdata = data_d;
      end
   end

   // R7
   no_r0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> rf_addr != '0);
endmodule

// File: rtl/dual_retire_wb.sv
module dual_retire_wb
   import wb_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int DATA_W  = 32,
   parameter int TAG_W   = 4,
   parameter bit REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_valid,
   output logic              int_ready,
   input  logic [1:0]        int_kind,
   input  logic [ADDR_W-1:0] int_dest,
   input  logic [DATA_W-1:0] int_value,
   input  logic [TAG_W-1:0]  int_tag,
   input  logic              fp_valid,
   output logic              fp_ready,
   input  logic              fp_nop,
   input  logic [ADDR_W-1:0] fp_dest,
   input  logic [DATA_W-1:0] fp_value,
   input  logic [TAG_W-1:0]  fp_tag,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              rf_we,
   output logic [ADDR_W-1:0] rf_addr,
   output logic [DATA_W-1:0] rf_wdata
);
   localparam logic [ADDR_W-1:0] REG_ZERO = '0;

   res_kind_e         ikind;
   logic              int_first;
   logic              int_fire, fp_fire;
   logic              is_load, load_wait, load_fire, held_v;
   logic [DATA_W-1:0] load_data;
   logic              we_d;
   logic [ADDR_W-1:0] addr_d;
   logic [DATA_W-1:0] data_d;

   always_comb ikind = res_kind_e'(int_kind);

   wb_age_order #(.TAG_W(TAG_W)) u_age (
      .a_tag  (int_tag),
      .b_tag  (fp_tag),
      .a_first(int_first)
   );

   always_comb begin
      int_ready = !fp_valid || int_first;
      fp_ready  = !int_valid || !int_first;
      int_fire  = int_valid && int_ready;
      fp_fire   = fp_valid && fp_ready;
      is_load   = ikind == KIND_LOAD;
      load_wait = int_valid && is_load && !int_ready;
      load_fire = int_fire && is_load;
   end

   wb_load_hold #(.DATA_W(DATA_W)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_wait(load_wait),
      .load_fire(load_fire),
      .mem_rdata(mem_rdata),
      .load_data(load_data),
      .held_v   (held_v)
   );

   always_comb begin
      we_d   = 1'b0;
      addr_d = '0;
      data_d = '0;
      if (int_fire) begin
         we_d   = kind_writes(ikind) && (int_dest != REG_ZERO);
         addr_d = int_dest;
         data_d = is_load ? load_data : int_value;
      end else if (fp_fire) begin
         we_d   = !fp_nop && (fp_dest != REG_ZERO);
         addr_d = fp_dest;
         data_d = fp_value;
      end
   end

   wb_rf_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_d    (we_d),
      .addr_d  (addr_d),
      .data_d  (data_d),
      .rf_we   (rf_we),
      .rf_addr (rf_addr),
      .rf_wdata(rf_wdata)
   );

   // R3
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid && fp_valid |-> $countones({int_ready, fp_ready}) == 1);
   // R1
   lone_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid && !fp_valid |-> int_ready);
   // R1
   lone_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fp_valid && !int_valid |-> fp_ready);
   // R9
   single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({int_fire, fp_fire}));
   // R4
   held_only_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_v |-> int_valid && is_load);
endmodule

// File: tb/test_dual_retire_wb.sv
module test_dual_retire_wb;
   localparam int AW = 5;
   localparam int DW = 32;
   localparam int TW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          int_valid = 0, fp_valid = 0, fp_nop = 0;
   logic [1:0]    int_kind = 0;
   logic [AW-1:0] int_dest = 0, fp_dest = 0;
   logic [DW-1:0] int_value = 0, fp_value = 0, mem_rdata = 0;
   logic [TW-1:0] int_tag = 0, fp_tag = 0;
   logic          int_ready, fp_ready, rf_we;
   logic [AW-1:0] rf_addr;
   logic [DW-1:0] rf_wdata;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   dual_retire_wb #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) i_dual_retire_wb (
      .clk(clk), .rst_n(rst_n),
      .int_valid(int_valid), .int_ready(int_ready), .int_kind(int_kind),
      .int_dest(int_dest), .int_value(int_value), .int_tag(int_tag),
      .fp_valid(fp_valid), .fp_ready(fp_ready), .fp_nop(fp_nop),
      .fp_dest(fp_dest), .fp_value(fp_value), .fp_tag(fp_tag),
      .mem_rdata(mem_rdata),
      .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
   );

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_int(logic v, logic [1:0] k, logic [AW-1:0] d,
                          logic [DW-1:0] val, logic [TW-1:0] t);
      int_valid = v; int_kind = k; int_dest = d; int_value = val; int_tag = t;
   endtask

   task automatic set_fp(logic v, logic n, logic [AW-1:0] d,
                         logic [DW-1:0] val, logic [TW-1:0] t);
      fp_valid = v; fp_nop = n; fp_dest = d; fp_value = val; fp_tag = t;
   endtask

   // checks readies before the edge, then the write port after it
   task automatic step(string req, logic ir, logic fr, logic we,
                       logic [AW-1:0] a, logic [DW-1:0] wd);
      #1;
      if (int_valid) check({req, " int_ready"}, int_ready, ir);
      if (fp_valid)  check({req, " fp_ready"}, fp_ready, fr);
      @(posedge clk); #1;
      check({req, " rf_we"}, rf_we, we);
      if (we) begin
         check({req, " rf_addr"}, rf_addr, a);
         check({req, " rf_wdata"}, rf_wdata, wd);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      set_int(0, 0, 0, 0, 0); set_fp(0, 0, 0, 0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check("R9 reset rf_we", rf_we, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 idle rf_we", rf_we, 0);
   endtask

   task automatic t_single();
      set_int(1, 0, 5'd3, 32'h1111, 4'd2);
      step("R1 int alone", 1, 0, 1, 5'd3, 32'h1111);
      set_int(0, 0, 0, 0, 0); set_fp(1, 0, 5'd4, 32'h2222, 4'd3);
      step("R1 fp alone", 0, 1, 1, 5'd4, 32'h2222);
      idle();
   endtask

   task automatic t_oldest();
      // fp tag 5 older than int tag 6
      set_int(1, 0, 5'd7, 32'hA7, 4'd6); set_fp(1, 0, 5'd8, 32'hF8, 4'd5);
      step("R2 fp older", 0, 1, 1, 5'd8, 32'hF8);
      set_fp(0, 0, 0, 0, 0);
      step("R3 held int retires", 1, 0, 1, 5'd7, 32'hA7);
      // int tag 9 older than fp tag 10
      set_int(1, 0, 5'd9, 32'hA9, 4'd9); set_fp(1, 0, 5'd10, 32'hFA, 4'd10);
      step("R2 int older", 1, 0, 1, 5'd9, 32'hA9);
      set_int(0, 0, 0, 0, 0);
      step("R3 held fp retires", 0, 1, 1, 5'd10, 32'hFA);
      idle();
   endtask

   task automatic t_wrap();
      // int tag 15 issued before fp tag 1 after wrap
      set_int(1, 0, 5'd11, 32'hB1, 4'd15); set_fp(1, 0, 5'd12, 32'hB2, 4'd1);
      step("R2 wrap int older", 1, 0, 1, 5'd11, 32'hB1);
      set_int(1, 0, 5'd13, 32'hB3, 4'd2); set_fp(1, 0, 5'd12, 32'hB2, 4'd14);
      step("R2 wrap fp older", 0, 1, 1, 5'd12, 32'hB2);
      set_fp(1, 0, 5'd14, 32'hB4, 4'd2);
      step("R2 equal tags int", 1, 0, 1, 5'd13, 32'hB3);
      set_int(0, 0, 0, 0, 0);
      step("R3 fp after tie", 0, 1, 1, 5'd14, 32'hB4);
      idle();
   endtask

   task automatic t_load_stall();
      set_int(1, 1, 5'd20, 32'h0, 4'd6); set_fp(1, 0, 5'd21, 32'hC1, 4'd4);
      mem_rdata = 32'hAAAA_0001;
      step("R4 load stalled 1", 0, 1, 1, 5'd21, 32'hC1);
      set_fp(1, 0, 5'd22, 32'hC2, 4'd5); mem_rdata = 32'hBBBB_0002;
      step("R4 load stalled 2", 0, 1, 1, 5'd22, 32'hC2);
      set_fp(0, 0, 0, 0, 0); mem_rdata = 32'hCCCC_0003;
      step("R4 stalled load uses saved data", 1, 0, 1, 5'd20, 32'hAAAA_0001);
      set_int(1, 1, 5'd23, 32'h0, 4'd7); mem_rdata = 32'hDDDD_0004;
      step("R8 next load uses live data", 1, 0, 1, 5'd23, 32'hDDDD_0004);
      idle();
   endtask

   task automatic t_live_load();
      set_int(1, 1, 5'd24, 32'h0, 4'd9); set_fp(1, 0, 5'd25, 32'hE5, 4'd10);
      mem_rdata = 32'h1234_5678;
      step("R5 load wins, live data", 1, 0, 1, 5'd24, 32'h1234_5678);
      set_int(0, 0, 0, 0, 0);
      step("R3 fp after load", 0, 1, 1, 5'd25, 32'hE5);
      idle();
   endtask

   task automatic t_no_write();
      set_int(1, 3, 5'd6, 32'h77, 4'd1);
      step("R6 jump accepted no write", 1, 0, 0, 0, 0);
      set_int(1, 2, 5'd6, 32'h77, 4'd2);
      step("R6 int nop no write", 1, 0, 0, 0, 0);
      set_int(0, 0, 0, 0, 0); set_fp(1, 1, 5'd6, 32'h88, 4'd3);
      step("R6 fp nop no write", 0, 1, 0, 0, 0);
      set_fp(1, 0, 5'd0, 32'h99, 4'd4);
      step("R7 fp dest zero", 0, 1, 0, 0, 0);
      set_fp(0, 0, 0, 0, 0); set_int(1, 0, 5'd0, 32'h99, 4'd5);
      step("R7 int dest zero", 1, 0, 0, 0, 0);
      idle();
      step("R9 idle no write", 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (2) @(posedge clk);
      t_reset();
      t_single();
      t_oldest();
      t_wrap();
      t_load_stall();
      t_live_load();
      t_no_write();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule